// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bubble Controller

This block is the purely combinational control unit of a five-stage processor pipeline whose stages are fetch, decode, execute, memory and write-back. It looks at the opcodes that sit in the decode, execute and memory stages, the load destination in execute, the two source registers read in decode, the branch condition that execute computed, and the status codes in memory and write-back. From these it decides, for every pipeline register, whether that register holds its contents (stall), loads an empty no-operation slot (bubble) or advances normally. It also decides whether the ALU may write the condition codes in the current cycle.

Four situations are handled. The first is a load or pop whose result is needed at once by the instruction in decode. The second is a return that is still in flight, so the next fetch address is not yet known. The third is a jump that was predicted taken but whose condition came out false. The fourth is an exception status, which must freeze the machine state. The controller also resolves overlaps between these situations, such as a load/use hazard while a return waits in decode. A pipeline register that is stalled keeps its value. A pipeline register that is bubbled takes the no-operation encoding. No stage may be told to do both at once.

Top module: `hzd_ctrl`

## Requirements
- R1: Encodings. The load opcode is 5, pop is 11, the ALU opcode is 6, jump is 7, return is 9, and no-operation is 1. The register id 15 means no register. The status codes are: bubble 0, ok 1, halt 2, address error 3, invalid instruction 4.
- R2: When execute holds a load or a pop whose destination equals decode source A or source B, the block asserts `f_stall`, `d_stall` and `e_bubble`.
- R3: A load or pop in execute whose destination is 15 never raises a load/use hazard, even when a decode source is also 15.
- R4: When return (9) is in decode, execute or memory, the block asserts `f_stall`. It also asserts `d_bubble` unless a load/use hazard is present at the same time.
- R5: When a load/use hazard and a pending return coincide, decode stalls (`d_stall`=1, `d_bubble`=0).
- R6: When execute holds a jump and `e_cond` is 0, the block asserts `d_bubble` and `e_bubble`.
- R7: A memory-stage status of halt, address error or invalid instruction asserts `m_bubble`.
- R8: A write-back status of halt, address error or invalid instruction asserts both `m_bubble` and `w_stall`.
- R9: `cc_write` is 1 exactly when execute holds the ALU opcode and neither the memory status nor the write-back status is an exception.
- R10: No stage is told to stall and to bubble in the same cycle.
- R11: When no hazard, return, mispredict or exception is present, every stall and bubble output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_op | input | 4 | Opcode in the decode stage |
| e_op | input | 4 | Opcode in the execute stage |
| m_op | input | 4 | Opcode in the memory stage |
| e_load_dst | input | 4 | Register written from memory by the execute-stage instruction |
| d_src_a | input | 4 | First source register read in decode |
| d_src_b | input | 4 | Second source register read in decode |
| e_cond | input | 1 | Condition result evaluated in execute |
| m_status | input | 3 | Status code of the memory stage |
| w_status | input | 3 | Status code of the write-back stage |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a no-operation into the decode register |
| e_bubble | output | 1 | Load a no-operation into the execute register |
| m_bubble | output | 1 | Load a no-operation into the memory register |
| w_stall | output | 1 | Hold the write-back register |
| cc_write | output | 1 | Permit the condition-code update |

## Verification
The bench tries every execute opcode against a grid of load destinations and decode sources. The grid includes equal ids, unequal ids and the no-register id 15. This separates true load/use matches from false ones and from the no-register case. The grid also crosses both condition values with a return present or absent in decode and in memory, which exposes the overlap of a load/use hazard with a return and the overlap of a mispredict with a return. A second sweep covers every pair of memory and write-back status codes, with and without an ALU op in execute. It tells the memory-only exception apart from the write-back exception, and it also shows that the unused codes 5 to 7 are not treated as exceptions.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int OPC_W  = 4;
    localparam int REG_W  = 4;
    localparam int STAT_W = 3;

    localparam logic [OPC_W-1:0] OPC_NOP  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_LOAD = 4'd5;
    localparam logic [OPC_W-1:0] OPC_ALU  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_JMP  = 4'd7;
    localparam logic [OPC_W-1:0] OPC_RET  = 4'd9;
    localparam logic [OPC_W-1:0] OPC_POP  = 4'd11;

    localparam logic [REG_W-1:0] REG_NONE = {REG_W{1'b1}};

    localparam logic [STAT_W-1:0] ST_BUB  = 3'd0;
    localparam logic [STAT_W-1:0] ST_OK   = 3'd1;
    localparam logic [STAT_W-1:0] ST_HALT = 3'd2;
    localparam logic [STAT_W-1:0] ST_ADDR = 3'd3;
    localparam logic [STAT_W-1:0] ST_BAD  = 3'd4;

    // Conditions found in the current cycle
    typedef struct packed {
        logic load_use;
        logic ret_pend;
        logic mispred;
        logic exc_mem;
        logic exc_wb;
    } hzd_cond_t;

    // Action for one pipeline register
    typedef struct packed {
        logic stall;
        logic bubble;
    } stage_act_t;

    function automatic logic is_exc(input logic [STAT_W-1:0] s);
        return (s == ST_HALT) || (s == ST_ADDR) || (s == ST_BAD);
    endfunction

    function automatic logic is_mem_read(input logic [OPC_W-1:0] op);
        return (op == OPC_LOAD) || (op == OPC_POP);
    endfunction

endpackage

// File: rtl/hzd_detect.sv
module hzd_detect
    import hzd_pkg::*;
(
    input  logic [OPC_W-1:0]  d_op,
    input  logic [OPC_W-1:0]  e_op,
    input  logic [OPC_W-1:0]  m_op,
    input  logic [REG_W-1:0]  e_load_dst,
    input  logic [REG_W-1:0]  d_src_a,
    input  logic [REG_W-1:0]  d_src_b,
    input  logic              e_cond,
    input  logic [STAT_W-1:0] m_status,
    input  logic [STAT_W-1:0] w_status,
    output hzd_cond_t         cond
);
    logic       dst_real;
    logic [1:0] src_hit;

    always_comb begin
        dst_real   = (e_load_dst != REG_NONE);
        src_hit[0] = (e_load_dst == d_src_a);
        src_hit[1] = (e_load_dst == d_src_b);

        cond.load_use = is_mem_read(e_op) && dst_real && (|src_hit);
        cond.ret_pend = (d_op == OPC_RET) || (e_op == OPC_RET) || (m_op == OPC_RET);
        cond.mispred  = (e_op == OPC_JMP) && !e_cond;
        cond.exc_mem  = is_exc(m_status);
        cond.exc_wb   = is_exc(w_status);
    end
endmodule

// File: rtl/hzd_stage_map.sv
module hzd_stage_map
    import hzd_pkg::*;
(
    input  hzd_cond_t  cond,
    output stage_act_t act_f,
    output stage_act_t act_d,
    output stage_act_t act_e,
    output stage_act_t act_m,
    output stage_act_t act_w
);
    always_comb begin
        act_f.stall  = cond.load_use || cond.ret_pend;
        act_f.bubble = 1'b0;

        // A return waiting behind a load/use hazard must not drop decode
        act_d.stall  = cond.load_use;
        act_d.bubble = cond.mispred || (cond.ret_pend && !cond.load_use);

        act_e.stall  = 1'b0;
        act_e.bubble = cond.mispred || cond.load_use;

        act_m.stall  = 1'b0;
        act_m.bubble = cond.exc_mem || cond.exc_wb;

        act_w.stall  = cond.exc_wb;
        act_w.bubble = 1'b0;
    end
endmodule

// File: rtl/hzd_cc_gate.sv
module hzd_cc_gate
    import hzd_pkg::*;
(
    input  logic [OPC_W-1:0] e_op,
    input  hzd_cond_t        cond,
    output logic             cc_write
);
    always_comb begin
        cc_write = (e_op == OPC_ALU) && !cond.exc_mem && !cond.exc_wb;
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
(
    input  logic [OPC_W-1:0]  d_op,
    input  logic [OPC_W-1:0]  e_op,
    input  logic [OPC_W-1:0]  m_op,
    input  logic [REG_W-1:0]  e_load_dst,
    input  logic [REG_W-1:0]  d_src_a,
    input  logic [REG_W-1:0]  d_src_b,
    input  logic              e_cond,
    input  logic [STAT_W-1:0] m_status,
    input  logic [STAT_W-1:0] w_status,
    output logic              f_stall,
    output logic              d_stall,
    output logic              d_bubble,
    output logic              e_bubble,
    output logic              m_bubble,
    output logic              w_stall,
    output logic              cc_write
);
    hzd_cond_t  cond;
    stage_act_t act_f, act_d, act_e, act_m, act_w;

    hzd_detect u_detect (
        .d_op       (d_op),
        .e_op       (e_op),
        .m_op       (m_op),
        .e_load_dst (e_load_dst),
        .d_src_a    (d_src_a),
        .d_src_b    (d_src_b),
        .e_cond     (e_cond),
        .m_status   (m_status),
        .w_status   (w_status),
        .cond       (cond)
    );

    hzd_stage_map u_map (
        .cond  (cond),
        .act_f (act_f),
        .act_d (act_d),
        .act_e (act_e),
        .act_m (act_m),
        .act_w (act_w)
    );

    hzd_cc_gate u_cc (
        .e_op     (e_op),
        .cond     (cond),
        .cc_write (cc_write)
    );

    assign f_stall  = act_f.stall;
    assign d_stall  = act_d.stall;
    assign d_bubble = act_d.bubble;
    assign e_bubble = act_e.bubble;
    assign m_bubble = act_m.bubble;
    assign w_stall  = act_w.stall;

    // Cross-module checks on the combined actions
    always_comb begin
        assert_stage_exclusive_R10: assert (!(act_d.stall && act_d.bubble) &&
                                            !(act_f.stall && act_f.bubble) &&
                                            !(act_e.stall && act_e.bubble) &&
                                            !(act_m.stall && act_m.bubble) &&
                                            !(act_w.stall && act_w.bubble))
            else $error("stage told to stall and bubble together");
        assert_ret_holds_fetch_R4: assert (!((d_op == OPC_RET) || (e_op == OPC_RET) ||
                                             (m_op == OPC_RET)) || f_stall)
            else $error("return in flight without fetch stall");
        assert_wb_freeze_R8: assert (!w_stall || m_bubble)
            else $error("write-back frozen while memory advances");
        assert_cc_quiet_R9: assert (!cc_write || !m_bubble)
            else $error("condition codes written during exception");
        assert_load_use_R2: assert (!d_stall || (f_stall && e_bubble))
            else $error("decode stall without fetch stall and execute bubble");
    end
endmodule

// File: tb/hzd_ctrl_bench.sv
module hzd_ctrl_bench;
    import hzd_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [3:0] d_op, e_op, m_op, e_load_dst, d_src_a, d_src_b;
    logic       e_cond;
    logic [2:0] m_status, w_status;
    logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_write;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    hzd_ctrl u_hzd_ctrl (
        .d_op(d_op), .e_op(e_op), .m_op(m_op), .e_load_dst(e_load_dst),
        .d_src_a(d_src_a), .d_src_b(d_src_b), .e_cond(e_cond),
        .m_status(m_status), .w_status(w_status),
        .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
        .e_bubble(e_bubble), .m_bubble(m_bubble), .w_stall(w_stall),
        .cc_write(cc_write)
    );

    task automatic check(input string tag, input string what,
                         input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b (d=%0d e=%0d m=%0d dst=%0d a=%0d b=%0d c=%0b ms=%0d ws=%0d)",
                     tag, what, got, exp, d_op, e_op, m_op, e_load_dst,
                     d_src_a, d_src_b, e_cond, m_status, w_status);
        end
    endtask

    function automatic logic exc_code(input logic [2:0] s);
        return (s == 3'd2) || (s == 3'd3) || (s == 3'd4);
    endfunction

    // Apply at a rising edge, sample at the following falling edge
    task automatic apply_and_check();
        logic lu, rt, mp, em, ew;
        @(negedge clk);
        lu = ((e_op == 4'd5) || (e_op == 4'd11)) && (e_load_dst != 4'd15) &&
             ((e_load_dst == d_src_a) || (e_load_dst == d_src_b));
        rt = (d_op == 4'd9) || (e_op == 4'd9) || (m_op == 4'd9);
        mp = (e_op == 4'd7) && (e_cond == 1'b0);
        em = exc_code(m_status);
        ew = exc_code(w_status);
        if (lu && rt) begin
            check("R5", "d_stall", d_stall, 1'b1);
            check("R5", "d_bubble", d_bubble, mp);
        end
        check(((e_load_dst == 4'd15) ? "R3" : "R2"), "f_stall", f_stall, lu || rt);
        check("R2", "d_stall", d_stall, lu);
        check((mp ? "R6" : "R2"), "e_bubble", e_bubble, lu || mp);
        check((mp ? "R6" : "R4"), "d_bubble", d_bubble, mp || (rt && !lu));
        check((ew ? "R8" : "R7"), "m_bubble", m_bubble, em || ew);
        check("R8", "w_stall", w_stall, ew);
        check("R9", "cc_write", cc_write, (e_op == 4'd6) && !em && !ew);
        check("R10", "d_excl", d_stall && d_bubble, 1'b0);
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] ids [4];
        ids[0] = 4'd0; ids[1] = 4'd2; ids[2] = 4'd3; ids[3] = 4'd15;

        // R11: quiet pipeline, all nop and ok
        @(posedge clk);
        d_op = 4'd1; e_op = 4'd1; m_op = 4'd1;
        e_load_dst = 4'd15; d_src_a = 4'd0; d_src_b = 4'd2;
        e_cond = 1'b1; m_status = 3'd1; w_status = 3'd1;
        @(negedge clk);
        check("R11", "f_stall", f_stall, 1'b0);
        check("R11", "d_stall", d_stall, 1'b0);
        check("R11", "d_bubble", d_bubble, 1'b0);
        check("R11", "e_bubble", e_bubble, 1'b0);
        check("R11", "m_bubble", m_bubble, 1'b0);
        check("R11", "w_stall", w_stall, 1'b0);
        @(posedge clk);

        // R1 encodings exercised through the sweeps below
        for (int eo = 0; eo < 16; eo++)
            for (int di = 0; di < 4; di++)
                for (int ai = 0; ai < 4; ai++)
                    for (int bi = 0; bi < 4; bi++)
                        for (int c = 0; c < 2; c++)
                            for (int rp = 0; rp < 4; rp++) begin
                                e_op       = 4'(eo);
                                e_load_dst = ids[di];
                                d_src_a    = ids[ai];
                                d_src_b    = ids[bi];
                                e_cond     = 1'(c);
                                d_op       = rp[0] ? 4'd9 : 4'd1;
                                m_op       = rp[1] ? 4'd9 : 4'd1;
                                m_status   = 3'd1;
                                w_status   = 3'd1;
                                apply_and_check();
                            end

        // Status sweep for R7, R8, R9
        d_op = 4'd1; m_op = 4'd1; e_load_dst = 4'd15;
        d_src_a = 4'd0; d_src_b = 4'd2; e_cond = 1'b1;
        for (int ms = 0; ms < 8; ms++)
            for (int ws = 0; ws < 8; ws++)
                for (int k = 0; k < 2; k++) begin
                    m_status = 3'(ms);
                    w_status = 3'(ws);
                    e_op     = k[0] ? 4'd6 : 4'd1;
                    apply_and_check();
                end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule